// File: doc/BRIEF.md
# Integer Execute ALU with Shared Immediate Operand

This block is the combinational arithmetic stage of a 32-bit integer pipeline. Every cycle it takes a 4-bit operation code, a two-bit form selector, the first register operand, the second register operand and a 16-bit immediate field. From these it produces one result word and an illegal-operation flag. One operation table covers both forms. The form selector decides only where the second operand comes from. In register form the second operand is the register value. In immediate form it is the immediate field, sign extended to the full word.

The unit computes addition, subtraction, the three bitwise operations, three shifts, signed and unsigned set-less-than, and the low word of a multiply. It has no clock and no state, and every output is a function of the present inputs. Division and jump-style codes are not handled here. It reports them, together with the codes no one has assigned and any form other than the two arithmetic forms, as illegal, and it drives the result to zero. The trap decision is left to the control-flow logic.

Top module: `alu_exec`

## Requirements
- R1: Code 0x0 returns A + B and code 0x1 returns A - B, both modulo 2^32.
- R2: Code 0x2 returns A AND B, code 0x3 returns A OR B and code 0x4 returns A XOR B.
- R3: Codes 0x5, 0x6 and 0x7 shift A by B[4:0], with all higher bits of B ignored. 0x5 shifts left and fills with zeros. 0x6 shifts right and fills with zeros. 0x7 shifts right and fills with copies of A[31].
- R4: Code 0x8 returns 1 when A is below B as two's-complement values and 0 otherwise. Code 0x9 does the same comparison on unsigned values. Bits 31:1 of either result are zero.
- R5: Code 0xA returns the low 32 bits of A multiplied by B.
- R6: With form 2'b00, B is the 16-bit immediate sign extended to 32 bits, and the register input has no effect. With form 2'b01, B is the register input, and the immediate has no effect.
- R7: Codes 0xB, 0xC, 0xD, 0xE and 0xF raise the illegal flag and force the result to zero.
- R8: A form value of 2'b10 or 2'b11 raises the illegal flag and forces the result to zero, whatever the code is.
- R9: Codes 0x0 to 0xA under form 2'b00 or 2'b01 hold the illegal flag low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 4 | Operation code, 0x0 to 0xF |
| form_sel | input | 2 | Operand form: 2'b00 immediate, 2'b01 register, other values illegal |
| opnd_a | input | 32 | First register operand |
| reg_b | input | 32 | Second register operand, used in register form |
| imm_field | input | 16 | Immediate field, sign extended in immediate form |
| result | output | 32 | Operation result, zero when illegal |
| illegal | output | 1 | High for an unsupported code or form |

## Verification
The embedded assertions are immediate checks that sample while the inputs are settled. They assume that no input carries an unknown value during evaluation. The bench meets this by driving every input to a defined value before each comparison and holding it through the settle delay. The assertions also assume that the form selector and the code change together as one instruction. The bench always applies a complete operand set at once, and it sweeps all sixteen codes and all four forms over the edge values 0, 1, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF. It then runs random operands for each code and form pair, with the unused input also randomised so that the form isolation is exercised.

// File: rtl/alu_pkg.sv
package alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'h0,
      OP_SUB  = 4'h1,
      OP_AND  = 4'h2,
      OP_OR   = 4'h3,
      OP_XOR  = 4'h4,
      OP_SLL  = 4'h5,
      OP_SRL  = 4'h6,
      OP_SRA  = 4'h7,
      OP_SLT  = 4'h8,
      OP_SLTU = 4'h9,
      OP_MUL  = 4'hA,
      OP_DIV  = 4'hB,
      OP_RSVC = 4'hC,
      OP_RSVD = 4'hD,
      OP_RSVE = 4'hE,
      OP_JREG = 4'hF
   } alu_op_e;

   typedef enum logic [1:0] {
      FORM_IMM = 2'b00,
      FORM_REG = 2'b01,
      FORM_X2  = 2'b10,
      FORM_X3  = 2'b11
   } alu_form_e;

   localparam int SHIFT_OPERATOR = 0;
   localparam int SHIFT_LOG_STAGES = 1;

endpackage

// File: rtl/alu_opb_sel.sv
module alu_opb_sel #(
   parameter int XLEN  = 32,
   parameter int IMM_W = 16
) (
   input  logic [1:0]       form_sel,
   input  logic [XLEN-1:0]  reg_b,
   input  logic [IMM_W-1:0] imm_field,
   output logic [XLEN-1:0]  opnd_b,
   output logic             form_ok
);
   import alu_pkg::*;

   localparam int PAD_W = XLEN - IMM_W;

   logic [XLEN-1:0] imm_left;
   logic [XLEN-1:0] imm_ext;

   generate
      if (PAD_W > 0) begin : g_pad
         assign imm_left = {imm_field, {PAD_W{1'b0}}};
         assign imm_ext  = $unsigned($signed(imm_left) >>> PAD_W);
      end else begin : g_nopad
         assign imm_left = imm_field;
         assign imm_ext  = imm_left;
      end
   endgenerate

   always_comb begin
      form_ok = 1'b1;
      opnd_b  = '0;
      case (form_sel)
         FORM_IMM: opnd_b = imm_ext;
         FORM_REG: opnd_b = reg_b;
         default:  form_ok = 1'b0;
      endcase
   end

   always_comb begin
      if (form_sel == FORM_IMM)
         AST_IMM_SIGN_FILL: assert (opnd_b[XLEN-1:IMM_W-1] == {(PAD_W+1){imm_field[IMM_W-1]}}
                                    && opnd_b[IMM_W-1:0] == imm_field); // R6
      if (form_sel == FORM_REG)
         AST_REG_PASS: assert (opnd_b == reg_b); // R6
   end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
   parameter int XLEN  = 32,
   parameter int STYLE = 1
) (
   input  logic [XLEN-1:0]         data,
   input  logic [$clog2(XLEN)-1:0] amt,
   output logic [XLEN-1:0]         shl,
   output logic [XLEN-1:0]         shr,
   output logic [XLEN-1:0]         sra
);
   import alu_pkg::*;

   localparam int SH_W = $clog2(XLEN);

   generate
      if (STYLE == SHIFT_LOG_STAGES) begin : g_stages
         logic [XLEN-1:0] l_st [SH_W+1];
         logic [XLEN-1:0] r_st [SH_W+1];
         logic [XLEN-1:0] a_st [SH_W+1];
         assign l_st[0] = data;
         assign r_st[0] = data;
         assign a_st[0] = data;
         for (genvar k = 0; k < SH_W; k++) begin : g_stage
            localparam int DIST = 1 << k;
            assign l_st[k+1] = amt[k] ? {l_st[k][XLEN-1-DIST:0], {DIST{1'b0}}} : l_st[k];
            assign r_st[k+1] = amt[k] ? {{DIST{1'b0}}, r_st[k][XLEN-1:DIST]} : r_st[k];
            assign a_st[k+1] = amt[k] ? {{DIST{a_st[k][XLEN-1]}}, a_st[k][XLEN-1:DIST]} : a_st[k];
         end
         assign shl = l_st[SH_W];
         assign shr = r_st[SH_W];
         assign sra = a_st[SH_W];
      end else begin : g_operator
         assign shl = data << amt;
         assign shr = data >> amt;
         assign sra = $unsigned($signed(data) >>> amt);
      end
   endgenerate

   always_comb begin
      if (amt == '0)
         AST_SHIFT_IDENTITY: assert (shl == data && shr == data && sra == data); // R3
      AST_SRA_SIGN: assert (sra[XLEN-1] == data[XLEN-1]); // R3
      AST_SHIFT_FILL: assert (shl[0] == (amt == '0 ? data[0] : 1'b0)
                              && shr[XLEN-1] == (amt == '0 ? data[XLEN-1] : 1'b0)); // R3
   end

endmodule

// File: rtl/alu_mul_lo.sv
module alu_mul_lo #(
   parameter int XLEN   = 32,
   parameter bit MUL_EN = 1'b1
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic [XLEN-1:0] prod_lo
);
   generate
      if (MUL_EN) begin : g_mul
         assign prod_lo = a * b;
      end else begin : g_nomul
         assign prod_lo = '0;
      end
   endgenerate

   always_comb begin
      if (MUL_EN && b == '0)
         AST_MUL_ZERO: assert (prod_lo == '0); // R5
      if (MUL_EN && b == {{(XLEN-1){1'b0}}, 1'b1})
         AST_MUL_ONE: assert (prod_lo == a); // R5
   end

endmodule

// File: rtl/alu_exec.sv
module alu_exec #(
   parameter int XLEN        = 32,
   parameter int IMM_W       = 16,
   parameter int SHIFT_STYLE = 1,
   parameter bit MUL_EN      = 1'b1
) (
   input  logic [3:0]       op_code,
   input  logic [1:0]       form_sel,
   input  logic [XLEN-1:0]  opnd_a,
   input  logic [XLEN-1:0]  reg_b,
   input  logic [IMM_W-1:0] imm_field,
   output logic [XLEN-1:0]  result,
   output logic             illegal
);
   import alu_pkg::*;

   localparam int SH_W = $clog2(XLEN);

   generate
      if (XLEN < 8 || (1 << SH_W) != XLEN) begin : g_bad_xlen
         $error("alu_exec: XLEN must be a power of two of at least 8");
      end
      if (IMM_W < 2 || IMM_W > XLEN) begin : g_bad_imm
         $error("alu_exec: IMM_W must lie between 2 and XLEN");
      end
      if (SHIFT_STYLE != SHIFT_OPERATOR && SHIFT_STYLE != SHIFT_LOG_STAGES) begin : g_bad_style
         $error("alu_exec: unknown SHIFT_STYLE");
      end
   endgenerate

   logic [XLEN-1:0] opnd_b;
   logic            form_ok;
   logic [XLEN-1:0] sh_l, sh_r, sh_a;
   logic [XLEN-1:0] prod_lo;
   logic            lt_s, lt_u;
   logic            code_ok;
   logic [XLEN-1:0] raw;

   alu_opb_sel #(.XLEN(XLEN), .IMM_W(IMM_W)) i_opb_sel (
      .form_sel  (form_sel),
      .reg_b     (reg_b),
      .imm_field (imm_field),
      .opnd_b    (opnd_b),
      .form_ok   (form_ok)
   );

   alu_shifter #(.XLEN(XLEN), .STYLE(SHIFT_STYLE)) i_shifter (
      .data (opnd_a),
      .amt  (opnd_b[SH_W-1:0]),
      .shl  (sh_l),
      .shr  (sh_r),
      .sra  (sh_a)
   );

   alu_mul_lo #(.XLEN(XLEN), .MUL_EN(MUL_EN)) i_mul_lo (
      .a       (opnd_a),
      .b       (opnd_b),
      .prod_lo (prod_lo)
   );

   assign lt_s = $signed(opnd_a) < $signed(opnd_b);
   assign lt_u = opnd_a < opnd_b;

   always_comb begin
      code_ok = 1'b1;
      raw     = '0;
      case (alu_op_e'(op_code))
         OP_ADD:  raw = opnd_a + opnd_b;
         OP_SUB:  raw = opnd_a - opnd_b;
         OP_AND:  raw = opnd_a & opnd_b;
         OP_OR:   raw = opnd_a | opnd_b;
         OP_XOR:  raw = opnd_a ^ opnd_b;
         OP_SLL:  raw = sh_l;
         OP_SRL:  raw = sh_r;
         OP_SRA:  raw = sh_a;
         OP_SLT:  raw = {{(XLEN-1){1'b0}}, lt_s};
         OP_SLTU: raw = {{(XLEN-1){1'b0}}, lt_u};
         OP_MUL: begin
            raw     = prod_lo;
            code_ok = MUL_EN;
         end
         default: code_ok = 1'b0;
      endcase
   end

   assign illegal = !(code_ok && form_ok);
   assign result  = illegal ? '0 : raw;

   always_comb begin
      if (illegal)
         AST_ILLEGAL_ZERO: assert (result == '0); // R7
      if (form_sel[1])
         AST_FORM_REJECT: assert (illegal); // R8
      if (op_code >= 4'hB)
         AST_CODE_REJECT: assert (illegal); // R7
      if (!form_sel[1] && op_code <= 4'h9)
         AST_LEGAL_CLEAR: assert (!illegal); // R9
      if (!illegal && (op_code == OP_SLT || op_code == OP_SLTU))
         AST_SLT_BOOL: assert (result[XLEN-1:1] == '0); // R4
      if (!illegal && op_code == OP_SUB)
         AST_SUB_INVERSE: assert (result + opnd_b == opnd_a); // R1
      if (!illegal && op_code == OP_XOR)
         AST_XOR_INVERSE: assert ((result ^ opnd_b) == opnd_a); // R2
   end

endmodule

// File: tb/test_alu_exec.sv
module test_alu_exec;
   localparam int CLK_PERIOD = 10;
   localparam int RAND_PER_PAIR = 150;

   logic        clk = 1'b0;
   logic [3:0]  op_code;
   logic [1:0]  form_sel;
   logic [31:0] opnd_a, reg_b;
   logic [15:0] imm_field;
   logic [31:0] result;
   logic        illegal;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   alu_exec i_alu_exec (
      .op_code   (op_code),
      .form_sel  (form_sel),
      .opnd_a    (opnd_a),
      .reg_b     (reg_b),
      .imm_field (imm_field),
      .result    (result),
      .illegal   (illegal)
   );

   function automatic string req_tag(input logic [3:0] op, input logic [1:0] fm);
      if (fm[1]) return "R8";
      case (op)
         4'h0, 4'h1:       return "R1";
         4'h2, 4'h3, 4'h4: return "R2";
         4'h5, 4'h6, 4'h7: return "R3";
         4'h8, 4'h9:       return "R4";
         4'hA:             return "R5";
         default:          return "R7";
      endcase
   endfunction

   task automatic apply_and_check(input logic [3:0] op, input logic [1:0] fm,
                                  input logic [31:0] a, input logic [31:0] rb,
                                  input logic [15:0] im);
      logic [31:0] b, exp_res;
      logic        exp_ill;
      @(negedge clk);
      op_code = op; form_sel = fm; opnd_a = a; reg_b = rb; imm_field = im;
      #1;
      // R6: immediate form sign extends, register form passes the register
      b = (fm == 2'b00) ? {{16{im[15]}}, im} : rb;
      exp_ill = 1'b0;
      case (op)
         4'h0: exp_res = a + b;
         4'h1: exp_res = a - b;
         4'h2: exp_res = a & b;
         4'h3: exp_res = a | b;
         4'h4: exp_res = a ^ b;
         4'h5: exp_res = a << b[4:0];
         4'h6: exp_res = a >> b[4:0];
         4'h7: exp_res = $unsigned($signed(a) >>> b[4:0]);
         4'h8: exp_res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
         4'h9: exp_res = (a < b) ? 32'd1 : 32'd0;
         4'hA: exp_res = a * b;
         default: begin exp_res = 32'd0; exp_ill = 1'b1; end
      endcase
      if (fm[1]) begin exp_res = 32'd0; exp_ill = 1'b1; end
      checks++;
      if (result !== exp_res) begin
         fails++;
         $display("FAIL %s/R6 result op=%h form=%b a=%h rb=%h imm=%h actual=%h expected=%h",
                  req_tag(op, fm), op, fm, a, rb, im, result, exp_res);
      end
      checks++;
      if (illegal !== exp_ill) begin
         fails++;
         $display("FAIL %s illegal flag (R9 when legal) op=%h form=%b actual=%b expected=%b",
                  req_tag(op, fm), op, fm, illegal, exp_ill);
      end
   endtask

   initial begin
      logic [31:0] edges [5];
      logic [15:0] iedges [5];
      edges[0] = 32'h0; edges[1] = 32'h1; edges[2] = 32'h7FFF_FFFF;
      edges[3] = 32'h8000_0000; edges[4] = 32'hFFFF_FFFF;
      iedges[0] = 16'h0; iedges[1] = 16'h1; iedges[2] = 16'h7FFF;
      iedges[3] = 16'h8000; iedges[4] = 16'hFFFF;

      // Idle state: all-zero inputs decode as a legal add of zeros (R1, R9)
      apply_and_check(4'h0, 2'b00, 32'h0, 32'h0, 16'h0);

      // Edge sweep: every code, every form, edge operands in both slots
      for (int op = 0; op < 16; op++)
         for (int fm = 0; fm < 4; fm++)
            for (int i = 0; i < 5; i++)
               for (int j = 0; j < 5; j++)
                  apply_and_check(4'(op), 2'(fm), edges[i], edges[j], iedges[j]);

      // R3: shift amounts with high B bits set must use only B[4:0]
      for (int op = 5; op < 8; op++)
         for (int s = 0; s < 32; s++) begin
            apply_and_check(4'(op), 2'b01, 32'h9234_5678, {27'h5A5A5A5, 5'(s)}, 16'hFFFF);
            apply_and_check(4'(op), 2'b00, 32'h8765_4321, 32'hFFFF_FFFF, {11'h7E1, 5'(s)});
         end

      // Random operands; the unused B source is randomised too (R6)
      for (int op = 0; op < 16; op++)
         for (int fm = 0; fm < 4; fm++)
            for (int n = 0; n < RAND_PER_PAIR; n++)
               apply_and_check(4'(op), 2'(fm), $urandom, $urandom, 16'($urandom));

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule